// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Programming

This block sits between a two-wire serial protocol engine and a nonvolatile byte array. The engine hands it a start address, then the data bytes of one write transaction, each with a one-cycle valid strobe. The block gathers those bytes into a page-sized staging buffer. Only the low offset bits of the address pointer move as bytes arrive, so a long transaction wraps around inside its page and later bytes replace earlier ones at the same offset.

A stop strobe ends the transaction. If at least one byte was gathered and the write-protect level is low, the whole page goes to the array in one write pulse, with a per-byte mask. A programming timer then holds `busy` high for a fixed number of timer ticks. While `busy` is high every input strobe is ignored. When the cycle ends, the shared address pointer is left on the last byte written, so that a later current-address read continues from there. A stop that finds write protect high, or no gathered byte, starts nothing and leaves `busy` low.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset `busy` is 0, `arr_we` is 0 and `ptr_addr` is 0.
- R2: `start_valid` loads `ptr_addr` from `start_addr`. Each accepted data byte is stored at offset `ptr_addr[PAGE_W-1:0]`. After it, only those low PAGE_W bits increment, wrapping from 2^PAGE_W-1 to 0, and the upper bits stay as they were.
- R3: When more than 2^PAGE_W bytes arrive before stop, a later byte replaces the earlier byte at the same offset. The committed page holds the last byte received at each offset.
- R4: The cycle after a commit stop (not busy, write protect low, at least one byte gathered), `arr_we` is 1 for exactly one cycle. In that cycle `arr_page` equals the upper pointer bits, bit i of `arr_wmask` is set exactly when offset i received a byte, and `arr_wdata[8i+7:8i]` holds the byte for offset i.
- R5: `busy` rises on the same edge as the `arr_we` pulse. It stays high until the timer has sampled exactly PROG_TICKS `tick` pulses while busy, and falls on the edge that samples the last of them.
- R6: A stop with `wp_level` high commits nothing: no `arr_we` pulse, and `busy` stays 0. The gathered bytes are dropped and do not appear in the mask of any later commit.
- R7: A stop with no byte gathered since the last stop commits nothing and leaves `busy` 0.
- R8: While `busy` is high, `start_valid`, `data_valid` and `stop_strobe` have no effect. `ptr_addr` is unchanged, no `arr_we` pulse occurs, and the bytes offered do not appear in the next commit.
- R9: When a programming cycle completes, `ptr_addr` becomes the address of the last accepted byte. A stop that commits nothing leaves `ptr_addr` unchanged.
- R10: The valid bits clear when a cycle starts, so the next transaction commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Load the address pointer from start_addr |
| start_addr | input | ADDR_W | Byte address at which the write begins |
| data_valid | input | 1 | One data byte is offered this cycle |
| data_byte | input | DATA_W | Data byte |
| stop_strobe | input | 1 | End of the write transaction |
| wp_level | input | 1 | Write protect; high makes the array read-only |
| tick | input | 1 | Timebase pulse for the programming timer |
| busy | output | 1 | Programming cycle in progress |
| ptr_addr | output | ADDR_W | Shared address pointer |
| arr_we | output | 1 | One-cycle page write pulse to the array |
| arr_page | output | ADDR_W-PAGE_W | Page number being written |
| arr_wmask | output | 2^PAGE_W | Per-byte write enable |
| arr_wdata | output | 2^PAGE_W*DATA_W | Page data, byte i in bits 8i+7:8i |

## Verification
Pointer updates, including the load from `start_addr` and each offset step, show on `ptr_addr` one edge after the input strobe. The write pulse and the rise of `busy` show one edge after the stop. The fall of `busy` and the pointer restore appear one edge after the last counted tick. The bench drives every input on the falling edge and reads the outputs on the following falling edge, so each result is read exactly one register stage after its cause. For the cycle length, the bench counts only the ticks it drove while it saw `busy` high, and compares that count with PROG_TICKS at the first falling edge where `busy` reads low.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // programming timer states
  typedef enum logic {
    PT_IDLE = 1'b0,
    PT_PROG = 1'b1
  } prog_state_e;

  // offset advance inside a page: wraps at the page size
  function automatic int unsigned offset_step(input int unsigned off,
                                              input int unsigned page_bytes);
    return (off + 1) % page_bytes;
  endfunction

endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              restore,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] last_addr
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W-1:0] next_off;

  assign next_off = PAGE_W'(offset_step(int'(ptr[PAGE_W-1:0]), PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      last_addr <= '0;
    end else if (restore) begin
      ptr <= last_addr;
    end else if (load) begin
      ptr <= load_addr;
    end else if (step) begin
      last_addr <= ptr;
      ptr       <= {ptr[ADDR_W-1:PAGE_W], next_off};
    end
  end

endmodule

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [PAGE_W-1:0]                wr_off,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             clr_valid,
  output logic [(1<<PAGE_W)*DATA_W-1:0]    page_data,
  output logic [(1<<PAGE_W)-1:0]           byte_valid
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
    logic [DATA_W-1:0] slot_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_en && (wr_off == PAGE_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (hit) slot_q <= wr_data;
        if (clr_valid)  vld_q <= 1'b0;
        else if (hit)   vld_q <= 1'b1;
      end
    end

    assign page_data[b*DATA_W +: DATA_W] = slot_q;
    assign byte_valid[b]                 = vld_q;
  end

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer
  import pwb_pkg::*;
#(
  parameter int PROG_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_TICKS - 1);

  prog_state_e      state;
  logic [CNT_W-1:0] cnt;

  assign busy = (state == PT_PROG);
  assign done = busy && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PT_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PT_IDLE: if (start) begin
          state <= PT_PROG;
          cnt   <= '0;
        end
        PT_PROG: if (tick) begin
          if (cnt == LAST) state <= PT_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= PT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  parameter int PROG_TICKS = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_valid,
  input  logic [ADDR_W-1:0]                 start_addr,
  input  logic                              data_valid,
  input  logic [DATA_W-1:0]                 data_byte,
  input  logic                              stop_strobe,
  input  logic                              wp_level,
  input  logic                              tick,
  output logic                              busy,
  output logic [ADDR_W-1:0]                 ptr_addr,
  output logic                              arr_we,
  output logic [ADDR_W-PAGE_W-1:0]          arr_page,
  output logic [(1<<PAGE_W)-1:0]            arr_wmask,
  output logic [(1<<PAGE_W)*DATA_W-1:0]     arr_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  // named internal events, also observed by the checker
  logic                      accept_start;
  logic                      accept_byte;
  logic                      stop_seen;
  logic                      commit_go;
  logic                      discard_stop;
  logic                      cycle_done;
  logic                      any_valid;
  logic [PAGE_BYTES-1:0]     byte_valid;
  logic [ADDR_W-1:0]         last_addr;

  assign stop_seen    = stop_strobe && !busy;
  assign accept_start = start_valid && !busy && !stop_strobe;
  assign accept_byte  = data_valid  && !busy && !stop_strobe;
  assign any_valid    = |byte_valid;
  assign commit_go    = stop_seen && any_valid && !wp_level;
  assign discard_stop = stop_seen && !commit_go;

  pwb_addr_ptr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_start),
    .load_addr (start_addr),
    .step      (accept_byte),
    .restore   (cycle_done),
    .ptr       (ptr_addr),
    .last_addr (last_addr)
  );

  pwb_page_buffer #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept_byte),
    .wr_off     (ptr_addr[PAGE_W-1:0]),
    .wr_data    (data_byte),
    .clr_valid  (stop_seen),
    .page_data  (arr_wdata),
    .byte_valid (byte_valid)
  );

  pwb_prog_timer #(
    .PROG_TICKS (PROG_TICKS)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .tick  (tick),
    .busy  (busy),
    .done  (cycle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      arr_page  <= '0;
      arr_wmask <= '0;
    end else begin
      arr_we <= commit_go;
      if (commit_go) begin
        arr_page  <= ptr_addr[ADDR_W-1:PAGE_W];
        arr_wmask <= byte_valid;
      end
    end
  end

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 4,
  parameter int PROG_TICKS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   busy,
  input logic                   start_valid,
  input logic [ADDR_W-1:0]      ptr_addr,
  input logic                   arr_we,
  input logic [(1<<PAGE_W)-1:0] arr_wmask,
  input logic                   accept_byte,
  input logic                   commit_go,
  input logic                   discard_stop,
  input logic                   cycle_done
);
  int unsigned busy_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_ticks <= 0;
    else if (commit_go)        busy_ticks <= 0;
    else if (busy && tick)     busy_ticks <= busy_ticks + 1;
  end

  // R4
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> (busy && arr_we));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  // R4
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wmask != '0));

  // R6
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard_stop |=> (!busy && !arr_we));

  // R8
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_done) |=> $stable(ptr_addr));

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_byte && !start_valid) |=>
      (ptr_addr[ADDR_W-1:PAGE_W] == $past(ptr_addr[ADDR_W-1:PAGE_W])));

  // R5
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_ticks == PROG_TICKS));

endmodule

bind pwb_page_writer pwb_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_W     (PAGE_W),
  .PROG_TICKS (PROG_TICKS)
) i_pwb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .busy         (busy),
  .start_valid  (start_valid),
  .ptr_addr     (ptr_addr),
  .arr_we       (arr_we),
  .arr_wmask    (arr_wmask),
  .accept_byte  (accept_byte),
  .commit_go    (commit_go),
  .discard_stop (discard_stop),
  .cycle_done   (cycle_done)
);

// File: tb/test_pwb_page_writer.sv
module test_pwb_page_writer;
  localparam int ADDR_W     = 10;
  localparam int PAGE_W     = 4;
  localparam int DATA_W     = 8;
  localparam int PROG_TICKS = 6;
  localparam int PB         = 1 << PAGE_W;
  localparam int WIDE       = PB * DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_valid = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              data_valid = 1'b0;
  logic [DATA_W-1:0] data_byte = '0;
  logic              stop_strobe = 1'b0;
  logic              wp_level = 1'b0;
  logic              tick = 1'b0;
  logic              busy;
  logic [ADDR_W-1:0] ptr_addr;
  logic              arr_we;
  logic [ADDR_W-PAGE_W-1:0] arr_page;
  logic [PB-1:0]     arr_wmask;
  logic [WIDE-1:0]   arr_wdata;

  always #5 clk = ~clk;

  pwb_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .PROG_TICKS(PROG_TICKS)
  ) i_pwb_page_writer (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .data_valid(data_valid), .data_byte(data_byte), .stop_strobe(stop_strobe),
    .wp_level(wp_level), .tick(tick), .busy(busy), .ptr_addr(ptr_addr),
    .arr_we(arr_we), .arr_page(arr_page), .arr_wmask(arr_wmask), .arr_wdata(arr_wdata)
  );

  int checks = 0;
  int errors = 0;

  // bench model
  logic [DATA_W-1:0] m_data [PB];
  bit                m_vld  [PB];
  int                m_ptr;
  int                m_last;
  int                tick_cnt;

  // observed outputs, sampled at the start of each drive step
  logic              o_busy, o_we;
  logic [ADDR_W-1:0] o_ptr;
  logic [ADDR_W-PAGE_W-1:0] o_page;
  logic [PB-1:0]     o_mask;
  logic [WIDE-1:0]   o_wdata;

  function automatic int next_addr(input int a);
    int base;
    base = a - (a % PB);
    return base + ((a % PB) + 1) % PB;
  endfunction

  function automatic logic [PB-1:0] exp_mask();
    logic [PB-1:0] m;
    m = '0;
    for (int i = 0; i < PB; i++) if (m_vld[i]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [WIDE-1:0] act,
                     input logic [WIDE-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one cycle: sample outputs, then drive inputs for the next rising edge
  task automatic drive(input bit sv, input int sa, input bit dv,
                       input logic [DATA_W-1:0] db, input bit sp, input bit junk);
    @(negedge clk);
    o_busy = busy; o_we = arr_we; o_ptr = ptr_addr; o_page = arr_page;
    o_mask = arr_wmask; o_wdata = arr_wdata;
    if (junk && o_busy) begin
      start_valid = ($urandom % 3) == 0;
      start_addr  = ADDR_W'($urandom);
      data_valid  = ($urandom % 2) == 0;
      data_byte   = DATA_W'($urandom);
      stop_strobe = ($urandom % 4) == 0;
    end else begin
      start_valid = sv;
      start_addr  = ADDR_W'(sa);
      data_valid  = dv;
      data_byte   = db;
      stop_strobe = sp;
    end
    tick = ($urandom % 3) == 0;
    if (o_busy && tick) tick_cnt++;
  endtask

  task automatic txn(input int sa, input int n, input bit wp);
    logic [DATA_W-1:0] b;
    bit commit;
    drive(1'b1, sa, 1'b0, '0, 1'b0, 1'b0);
    m_ptr = sa;
    for (int i = 0; i < n; i++) begin
      b = DATA_W'($urandom);
      drive(1'b0, 0, 1'b1, b, 1'b0, 1'b0);
      m_data[m_ptr % PB] = b;
      m_vld[m_ptr % PB]  = 1'b1;
      m_last = m_ptr;
      m_ptr  = next_addr(m_ptr);
    end
    wp_level = wp;
    tick_cnt = 0;
    drive(1'b0, 0, 1'b0, '0, 1'b1, 1'b0);
    commit = (exp_mask() != '0) && !wp;
    drive(1'b0, 0, 1'b0, '0, 1'b0, 1'b1);
    wp_level = 1'b0;
    if (commit) begin
      chk("R4 arr_we pulse", WIDE'(o_we), WIDE'(1));
      chk("R5 busy rise", WIDE'(o_busy), WIDE'(1));
      chk("R4 arr_page", WIDE'(o_page), WIDE'(m_ptr / PB));
      chk("R4 R10 arr_wmask", WIDE'(o_mask), WIDE'(exp_mask()));
      for (int i = 0; i < PB; i++)
        if (m_vld[i]) chk("R3 arr_wdata byte", WIDE'(o_wdata[i*DATA_W +: DATA_W]),
                          WIDE'(m_data[i]));
      for (int i = 0; i < PB; i++) m_vld[i] = 1'b0;
      for (int g = 0; g < 400 && o_busy; g++) begin
        drive(1'b0, 0, 1'b0, '0, 1'b0, 1'b1);
        if (o_busy) begin
          chk("R8 ptr frozen", WIDE'(o_ptr), WIDE'(m_ptr));
          chk("R4 R8 no second pulse", WIDE'(o_we), WIDE'(0));
        end
      end
      chk("R5 busy ticks", WIDE'(tick_cnt), WIDE'(PROG_TICKS));
      chk("R9 ptr restored", WIDE'(o_ptr), WIDE'(m_last));
      m_ptr = m_last;
    end else begin
      chk(wp ? "R6 no pulse" : "R7 no pulse", WIDE'(o_we), WIDE'(0));
      chk(wp ? "R6 busy low" : "R7 busy low", WIDE'(o_busy), WIDE'(0));
      chk("R9 ptr kept", WIDE'(o_ptr), WIDE'(m_ptr));
      for (int i = 0; i < PB; i++) m_vld[i] = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < PB; i++) begin m_data[i] = '0; m_vld[i] = 1'b0; end
    m_ptr = 0; m_last = 0; tick_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 0, 1'b0, '0, 1'b0, 1'b0);
    chk("R1 busy", WIDE'(o_busy), WIDE'(0));
    chk("R1 arr_we", WIDE'(o_we), WIDE'(0));
    chk("R1 ptr", WIDE'(o_ptr), WIDE'(0));
    // directed corners
    txn(10'h3F5, 16, 1'b0);   // R2 full page, wraps past the page end
    txn(10'h123, 20, 1'b0);   // R3 overwrite after wrap
    txn(10'h08F, 1, 1'b0);    // R9 single byte at last offset
    txn(10'h200, 0, 1'b0);    // R7 empty stop
    txn(10'h044, 3, 1'b1);    // R6 protected
    txn(10'h04A, 2, 1'b0);    // R6 R10 earlier bytes must be absent
    // constrained random
    for (int t = 0; t < 40; t++)
      txn(int'($urandom % (1 << ADDR_W)), int'($urandom_range(0, 20)),
          ($urandom % 5) == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule